// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is a single 16-bit up-counter, fed by a selectable power-of-two prescaler, that serves either as a watchdog or as a periodic interval timer. In interval mode every overflow sets a sticky status flag and raises an interrupt, and the counter wraps and keeps running. In watchdog mode software must restart the count in time by writing a two-word key to a restart register. If it does not, the overflow produces either a fixed-length reset pulse or an interrupt, as configured.

Software drives the block through a small register port with four word addresses. The control word holds the run bit, the mode, the watchdog action and the prescaler select. While the timer runs, only the run bit can be changed. The prescaler range is wide enough that the longest period is well over 200 ms at a 33 MHz system clock (2^16 x 2^14 cycles with the default parameters). The clock source and the chip reset network lie outside the block.

Top module: `wdog_itimer`

## Requirements
- R1: After reset, CTRL (address 0), STATUS (address 2) and COUNT (address 3) read 0, and both `irq_o` and `wdt_rst_o` are low.
- R2: CTRL fields: bit 0 run, bit 1 mode (1 = interval, 0 = watchdog), bit 2 watchdog action (1 = interrupt, 0 = reset), bits [3 +: SEL_W] prescaler select s. The first overflow occurs on the clock edge exactly 2^CNT_W * 2^(s*PSC_STEP) cycles after the edge that writes run = 1.
- R3: In interval mode an overflow sets the status flag and raises `irq_o`. The counter wraps to 0 and keeps counting, so the next overflow follows one period later.
- R4: STATUS bit 0 is the overflow flag. Writing 1 to it clears the flag, and writing 0 leaves it unchanged. `irq_o` is high only while the flag is set and the configuration selects an interrupt (interval mode, or watchdog mode with action = 1).
- R5: In watchdog mode with action = 0, an overflow sets the flag and drives `wdt_rst_o` high for exactly RST_LEN consecutive cycles, starting on the overflow edge. `irq_o` stays low.
- R6: In watchdog mode with action = 1, an overflow raises `irq_o`, and `wdt_rst_o` stays low.
- R7: In watchdog mode while running, a write of 0x003C to KICK (address 1), followed directly by a write of 0x00C3 as the next KICK write, restarts the counter and the prescaler at 0. The next overflow then falls one full period after the edge of the 0x00C3 write.
- R8: Any other KICK write has no restart effect. This covers a 0x00C3 that does not directly follow 0x003C, and any key written in interval mode.
- R9: While run is 1, a CTRL write changes only the run bit, and the mode, action and select fields keep their values. While run is 0, the counter and the prescaler are held at 0.
- R10: COUNT returns the current counter value, zero-extended to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Overflow interrupt (level) |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench builds the block with CNT_W = 8 and PSC_STEP = 1, which makes a period 256 cycles at select 0 and 512 cycles at select 1. Every overflow edge is therefore reachable within a few hundred cycles, and can be predicted exactly from the edge of the write that starts or restarts the timer. RST_LEN stays at 16, so the full reset pulse is measured. The short periods also allow a good key, a broken key and an interval-mode key to be placed ahead of an overflow and told apart by its timing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_KICK  = 2'd1,
    REG_STAT  = 2'd2,
    REG_COUNT = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_ACT_BIT  = 2;
  localparam int CTRL_SEL_LSB  = 3;

  localparam logic [15:0] KEY_ARM  = 16'h003C;
  localparam logic [15:0] KEY_FIRE = 16'h00C3;

  // number of low prescaler bits that must be all ones for a tick
  function automatic int tick_shift(input int sel, input int step);
    return sel * step;
  endfunction

  // width of the free prescaler so the largest select fits
  function automatic int psc_width(input int sel_w, input int step);
    int w;
    w = ((1 << sel_w) - 1) * step;
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W    = 3,
  parameter int PSC_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  import wdog_pkg::*;

  localparam int PW = psc_width(SEL_W, PSC_STEP);

  logic [PW-1:0] psc_q;
  logic [PW-1:0] mask;
  int            shift;

  always_comb begin
    shift = tick_shift(int'(sel_i), PSC_STEP);
    for (int i = 0; i < PW; i++) begin
      mask[i] = (i < shift);
    end
  end

  assign tick_o = run_i && (&(psc_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               psc_q <= '0;
    else if (!run_i || clr_i)  psc_q <= '0;
    else                       psc_q <= psc_q + 1'b1;
  end

  AST_PSC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || clr_i) |=> (psc_q == '0)) else $error("prescaler not held"); // R9

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = run_i && tick_i && !clr_i && (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || clr_i)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0)) else $error("no wrap after overflow"); // R3
  AST_KICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)) else $error("restart missed"); // R7
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)) else $error("counter moved while stopped"); // R9
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !clr_i) |=> $stable(cnt_q)) else $error("count without tick"); // R2

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] LEN = RW'(RST_LEN);

  logic [RW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= LEN;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  AST_RST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != '0 && !fire_i) |=> (left_q == $past(left_q) - 1'b1))
    else $error("reset pulse length broken"); // R5
  AST_RST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pulse_o) else $error("reset pulse not started"); // R5

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              run_o,
  output logic              interval_o,
  output logic              act_irq_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              flag_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  import wdog_pkg::*;

  logic             run_q, interval_q, act_q, flag_q, armed_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_ctrl, wr_kick, wr_stat;
  logic             key_arm, key_fire;

  assign wr_ctrl  = wr_en_i && (addr_i == REG_CTRL);
  assign wr_kick  = wr_en_i && (addr_i == REG_KICK);
  assign wr_stat  = wr_en_i && (addr_i == REG_STAT);
  assign key_arm  = (wdata_i == DATA_W'(KEY_ARM));
  assign key_fire = (wdata_i == DATA_W'(KEY_FIRE));

  // restart only in watchdog mode while running, after a directly preceding arm
  assign kick_o = wr_kick && key_fire && armed_q && run_q && !interval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      interval_q <= 1'b0;
      act_q      <= 1'b0;
      sel_q      <= '0;
    end else if (wr_ctrl) begin
      run_q <= wdata_i[CTRL_RUN_BIT];
      if (!run_q) begin
        interval_q <= wdata_i[CTRL_MODE_BIT];
        act_q      <= wdata_i[CTRL_ACT_BIT];
        sel_q      <= wdata_i[CTRL_SEL_LSB +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_kick) armed_q <= key_arm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= 1'b0;
    else if (ovf_i)                     flag_q <= 1'b1;
    else if (wr_stat && wdata_i[0])     flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_RUN_BIT]              = run_q;
        rdata_o[CTRL_MODE_BIT]             = interval_q;
        rdata_o[CTRL_ACT_BIT]              = act_q;
        rdata_o[CTRL_SEL_LSB +: SEL_W]     = sel_q;
      end
      REG_STAT:  rdata_o[0] = flag_q;
      REG_COUNT: rdata_o[CNT_W-1:0] = cnt_i;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o      = run_q;
  assign interval_o = interval_q;
  assign act_irq_o  = act_q;
  assign sel_o      = sel_q;
  assign flag_o     = flag_q;

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> ($stable(interval_q) && $stable(act_q) && $stable(sel_q)))
    else $error("config changed while running"); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_stat && wdata_i[0])) |=> flag_q) else $error("flag lost"); // R4
  AST_OVF_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_q) else $error("overflow not flagged"); // R3

endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer #(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int PSC_STEP = 2,
  parameter int RST_LEN  = 16,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  // named internal events
  logic             run, interval, act_irq, flag, kick, tick, ovf, fire;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ovf_i      (ovf),
    .cnt_i      (cnt),
    .run_o      (run),
    .interval_o (interval),
    .act_irq_o  (act_irq),
    .sel_o      (sel),
    .flag_o     (flag),
    .kick_o     (kick),
    .rdata_o    (rdata_o)
  );

  wdog_prescaler #(.SEL_W(SEL_W), .PSC_STEP(PSC_STEP)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (kick),
    .sel_i  (sel),
    .tick_o (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick),
    .clr_i  (kick),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  assign fire = ovf && !interval && !act_irq;

  wdog_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .pulse_o (wdt_rst_o)
  );

  assign irq_o = flag && (interval || act_irq);

  AST_RST_ONLY_WDOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> (!interval && !act_irq)) else $error("reset from wrong mode"); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag) else $error("irq without flag"); // R4
  AST_NO_IRQ_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> !irq_o) else $error("irq with reset action"); // R5

endmodule

// File: tb/test_wdog_itimer.sv
module test_wdog_itimer;
  localparam int CNT_W = 8, SEL_W = 3, STEP = 1, RLEN = 16, DW = 16;
  localparam int K_IRQ = 0, K_RST = 1;

  typedef struct { int kind; int cyc; } exp_t;

  logic          clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, wrst;
  int            cyc = 0, checks = 0, errors = 0;
  bit            done = 0;
  exp_t          q[$];

  wdog_itimer #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PSC_STEP(STEP), .RST_LEN(RLEN), .DATA_W(DW))
    i_wdog_itimer (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
                   .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(input int sel);
    return (1 << CNT_W) * (1 << (sel * STEP));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, output int edge_cyc);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 edge_cyc = cyc;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; #1 v = int'(rdata);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected events on each rising output
  bit prev_irq = 0, prev_rst = 0;
  int rst_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((irq && !prev_irq) || (wrst && !prev_rst)) begin
        int kind;
        kind = wrst && !prev_rst ? K_RST : K_IRQ;
        if (q.size() == 0) chk(0, "R2 unexpected event", kind, -1);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == kind, "R5/R6 event kind", kind, e.kind);
          chk(e.cyc == cyc, "R2 overflow cycle", cyc, e.cyc);
        end
      end
      if (wrst) rst_w++;
      else if (prev_rst) begin
        chk(rst_w == RLEN, "R5 pulse width", rst_w, RLEN);
        rst_w = 0;
      end
      prev_irq = irq; prev_rst = wrst;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, k, v, c1, c2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 count", v, 0);
    chk(irq == 0 && wrst == 0, "R1 outputs", {irq, wrst}, 0);

    // R3 interval mode, select 0
    wr(2'd0, 16'h0003, e);
    q.push_back('{K_IRQ, e + period(0)});
    q.push_back('{K_IRQ, e + 2 * period(0)});
    wait_until(e + period(0) + 4);
    rd(2'd3, v); chk(v < 8, "R3 counter wrapped", v, 3);
    wr(2'd2, 16'h0001, k);
    @(negedge clk); chk(irq == 0, "R4 clear by 1", irq, 0);
    wait_until(e + 2 * period(0) + 4);
    chk(irq == 1, "R3 second overflow", irq, 1);
    wr(2'd2, 16'h0000, k);
    @(negedge clk); chk(irq == 1, "R4 write 0 ignored", irq, 1);
    rd(2'd2, v); chk(v == 1, "R4 flag read", v, 1);
    wr(2'd2, 16'h0001, k);
    // R9 lock while running
    wr(2'd0, 16'h0003 | (16'd5 << 3), k);
    rd(2'd0, v); chk(v == 3, "R9 config locked", v, 3);
    wr(2'd0, 16'h0000, k);
    rd(2'd3, v); chk(v == 0, "R9 stopped count", v, 0);
    rd(2'd0, v); chk(v == 2, "R9 run cleared", v, 2);

    // R8 key ignored in interval mode, R10 count visible
    wr(2'd0, 16'h0003, e);
    wait_until(e + 60);
    rd(2'd3, c1); chk(c1 > 50 && c1 < 64, "R10 count value", c1, 60);
    wr(2'd1, 16'h003C, k); wr(2'd1, 16'h00C3, k);
    rd(2'd3, c2); chk(c2 > c1, "R8 interval kick ignored", c2, c1 + 5);
    wr(2'd0, 16'h0000, k);

    // R5 watchdog reset action, select 1, with restart
    wr(2'd0, 16'h0009, e);
    wait_until(e + 300);
    wr(2'd1, 16'h003C, k); wr(2'd1, 16'h00C3, k);
    rd(2'd3, v); chk(v <= 1, "R7 restart", v, 0);
    q.push_back('{K_RST, k + period(1)});
    wait_until(k + 100);
    wr(2'd1, 16'h003C, c1); wr(2'd1, 16'h0055, c1); wr(2'd1, 16'h00C3, c1);
    wr(2'd1, 16'h00C3, c1);
    rd(2'd3, v); chk(v >= 40, "R8 broken key ignored", v, 50);
    wait_until(k + period(1) + 40);
    chk(irq == 0 && wrst == 0, "R5 no irq after reset", {irq, wrst}, 0);
    rd(2'd2, v); chk(v == 1, "R5 flag set", v, 1);
    wr(2'd0, 16'h0000, c1); wr(2'd2, 16'h0001, c1);
    rd(2'd2, v); chk(v == 0, "R4 flag cleared", v, 0);

    // R6 watchdog interrupt action
    wr(2'd0, 16'h0005, e);
    q.push_back('{K_IRQ, e + period(0)});
    wait_until(e + period(0) + 10);
    chk(irq == 1, "R6 irq raised", irq, 1);
    chk(wrst == 0, "R6 no reset", wrst, 0);
    wr(2'd0, 16'h0000, k); wr(2'd2, 16'h0001, k);
    @(negedge clk); chk(irq == 0, "R4 irq follows flag", irq, 0);

    chk(q.size() == 0, "R2 all events seen", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule